// File: doc/BRIEF.md
# ADC Sample Serial Transmitter

This controller runs an external 8-bit analog-to-digital converter without pause and sends each result out on an asynchronous serial line. For each sample it pulses a start-conversion strobe and waits for the converter to report completion. It then captures the result and shifts it out as one frame. The frame has no parity and ends with two stop bits. A parameter sets the number of system clocks in each bit time.

When a frame has fully left the line, the controller spends one idle cycle and then starts the next conversion. A downstream receiver therefore sees a steady stream of samples, with the ADC rate bounded by the frame length. The busy flag covers the whole span from the strobe to the end of the last stop bit.

Top module: `adc_uart_sender`

## Requirements
- R1: While rst_ni is low, txd_o is 1, sc_o is 0 and busy_o is 0.
- R2: The first cycle after reset release, and the cycle after each idle cycle, has sc_o high, and sc_o is high for exactly one cycle. The idle cycle follows reset or the end of a frame.
- R3: busy_o is high from the cycle in which sc_o is high until the last stop bit ends. It is low in the single idle cycle between frames.
- R4: While it waits for the converter, the block captures adc_data_i on the first rising edge where eoc_i is 1. A later change of adc_data_i has no effect on the frame being sent.
- R5: Starting in the cycle after the capture edge, txd_o sends a start bit of 0 and then the 8 data bits, least significant bit first.
- R6: Two stop bits at level 1 follow the data bits, for 11 bit times per frame.
- R7: Every bit of the frame, the start and stop bits included, holds for exactly CLKS_PER_BIT clock cycles.
- R8: eoc_i has no effect while a frame is being sent, and sc_o stays low until the frame is complete.
- R9: txd_o stays 1 while the block waits for eoc_i and during the idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eoc_i | input | 1 | Converter end-of-conversion |
| adc_data_i | input | 8 | Converter result |
| sc_o | output | 1 | Start-conversion strobe, one cycle |
| busy_o | output | 1 | Conversion or frame in progress |
| txd_o | output | 1 | Serial line, idle high |

## Verification
The hardest case to reach is a converter that misbehaves while a frame is in flight. In that case eoc_i is raised again and adc_data_i changes in the middle of a transmission. The bench does this on purpose in one frame and expects an unchanged frame and no early strobe. It also varies the delay between the strobe and eoc_i, including no delay, and pulls reset in the middle of a frame to check that the line returns high at once.

// File: rtl/adc_tx_pkg.sv
package adc_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SC   = 2'd1,
    ST_WAIT = 2'd2,
    ST_SEND = 2'd3
  } ctl_state_e;
endpackage

// File: rtl/adc_tx_baud.sv
module adc_tx_baud #(
  parameter int CLKS_PER_BIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!run_i)       cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/adc_tx_shift.sv
module adc_tx_shift #(
  parameter int DATA_W    = 8,
  parameter int STOP_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  output logic              txd_o,
  output logic              last_o
);
  localparam int FRAME_W = 1 + DATA_W + STOP_BITS;
  localparam int IW = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sh_q;
  logic [IW-1:0]      idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '1;
      idx_q <= '0;
    end else if (load_i) begin
      sh_q  <= {{STOP_BITS{1'b1}}, data_i, 1'b0};
      idx_q <= '0;
    end else if (shift_i) begin
      sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
      idx_q <= idx_q + 1'b1;
    end
  end

  assign txd_o  = sh_q[0];
  assign last_o = (idx_q == IW'(FRAME_W - 1));
endmodule

// File: rtl/adc_tx_ctl.sv
module adc_tx_ctl
  import adc_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       eoc_i,
  input  logic       tick_i,
  input  logic       last_i,
  output ctl_state_e state_o,
  output logic       load_o
);
  ctl_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: st_d = ST_SC;
      ST_SC:   st_d = ST_WAIT;
      ST_WAIT: if (eoc_i) st_d = ST_SEND;
      ST_SEND: if (tick_i && last_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
  assign load_o  = (st_q == ST_WAIT) && eoc_i;
endmodule

// File: rtl/adc_uart_sender.sv
module adc_uart_sender
  import adc_tx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 4,
  parameter int DATA_W       = 8,
  parameter int STOP_BITS    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eoc_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              sc_o,
  output logic              busy_o,
  output logic              txd_o
);
  ctl_state_e state;
  logic load, tick, last;

  adc_tx_ctl u_ctl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .eoc_i  (eoc_i),
    .tick_i (tick),
    .last_i (last),
    .state_o(state),
    .load_o (load)
  );

  adc_tx_baud #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_baud (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state == ST_SEND),
    .tick_o(tick)
  );

  adc_tx_shift #(.DATA_W(DATA_W), .STOP_BITS(STOP_BITS)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .data_i (adc_data_i),
    .shift_i(tick),
    .txd_o  (txd_o),
    .last_o (last)
  );

  assign sc_o   = (state == ST_SC);
  assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/adc_uart_sender_chk.sv
module adc_uart_sender_chk #(
  parameter int CLKS_PER_BIT = 4,
  parameter int DATA_W       = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              eoc_i,
  input logic [DATA_W-1:0] adc_data_i,
  input logic              sc_o,
  input logic              busy_o,
  input logic              txd_o
);
  logic [15:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       run_q <= 16'd1;
    else if (txd_o != $past(txd_o))    run_q <= 16'd1;
    else if (run_q != 16'hffff)        run_q <= run_q + 1'b1;
  end

  a_r2_sc_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_o |=> !sc_o);

  a_r3_busy_starts_with_sc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> sc_o);

  a_r3_sc_is_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_o |-> busy_o);

  a_r9_idle_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> txd_o);

  a_r7_min_bit_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && txd_o != $past(txd_o)) |-> run_q >= 16'(CLKS_PER_BIT));
endmodule

bind adc_uart_sender adc_uart_sender_chk #(
  .CLKS_PER_BIT(CLKS_PER_BIT),
  .DATA_W      (DATA_W)
) u_chk (.*);

// File: tb/sim_adc_uart_sender.sv
module sim_adc_uart_sender;
  localparam int CPB = 4;
  localparam int NV  = 6;
  // {eoc delay after strobe, data}
  localparam logic [15:0] VEC [NV] = '{
    {8'd0, 8'hA5}, {8'd3, 8'h00}, {8'd1, 8'hFF},
    {8'd7, 8'h3C}, {8'd2, 8'h81}, {8'd5, 8'h5A}
  };

  logic clk = 1'b0, rst_n = 1'b0, eoc = 1'b0;
  logic [7:0] adc = 8'h00;
  logic sc, busy, txd;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  adc_uart_sender #(.CLKS_PER_BIT(CPB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .eoc_i(eoc), .adc_data_i(adc),
    .sc_o(sc), .busy_o(busy), .txd_o(txd)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Entered at the negedge where sc is high; returns at the next such negedge.
  task automatic frame(input logic [7:0] d, input int dly, input bit noise);
    logic [10:0] exp_f;
    exp_f = {2'b11, d, 1'b0};
    @(negedge clk);
    check(sc == 1'b0, "R2 strobe one cycle", sc, 0);
    check(busy == 1'b1 && txd == 1'b1, "R3/R9 waiting", {busy, txd}, 3);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      check(txd == 1'b1 && busy == 1'b1 && sc == 1'b0, "R9 wait line", {busy, txd, sc}, 6);
    end
    eoc = 1'b1;
    adc = d;
    for (int b = 0; b < 11; b++) begin
      bit ok = 1'b1;
      logic bad = 1'b0;
      for (int c = 0; c < CPB; c++) begin
        @(negedge clk);
        if (b == 0 && c == 0) begin
          eoc = 1'b0;
          adc = ~d; // R4 late data change must not matter
        end
        if (noise && b == 4) eoc = 1'b1;  // R8 stray eoc mid frame
        if (noise && b == 6) eoc = 1'b0;
        if (txd != exp_f[b]) begin ok = 1'b0; bad = txd; end
        if (sc != 1'b0 || busy != 1'b1) begin
          check(1'b0, "R8/R3 no strobe, busy in frame", {sc, busy}, 1);
        end
      end
      check(ok, b == 0 ? "R5/R7 start bit" : (b < 9 ? "R4/R5/R7 data bit" : "R6/R7 stop bit"),
            ok ? exp_f[b] : bad, exp_f[b]);
    end
    eoc = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && txd == 1'b1 && sc == 1'b0, "R3/R9 idle gap", {busy, txd, sc}, 2);
    @(negedge clk);
    check(sc == 1'b1 && busy == 1'b1, "R2 next strobe", {sc, busy}, 3);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(txd == 1'b1 && sc == 1'b0 && busy == 1'b0, "R1 reset outputs", {txd, sc, busy}, 4);
    rst_n = 1'b1;
    @(negedge clk);
    check(sc == 1'b1 && busy == 1'b1, "R2 first strobe", {sc, busy}, 3);

    for (int v = 0; v < NV; v++) frame(VEC[v][7:0], int'(VEC[v][15:8]), 1'b0);

    // stray eoc during a frame
    frame(8'hC3, 2, 1'b1);

    // reset mid frame
    @(negedge clk);
    eoc = 1'b1;
    adc = 8'h0F;
    repeat (CPB * 3) @(negedge clk);
    eoc = 1'b0;
    rst_n = 1'b0;
    #1;
    check(txd == 1'b1 && sc == 1'b0 && busy == 1'b0, "R1 async reset mid frame", {txd, sc, busy}, 4);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sc == 1'b1, "R2 strobe after reset", sc, 1);
    frame(8'h96, 0, 1'b0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule